// File: doc/BRIEF.md
# Outbound MMIO Window Decoder with Partition Mapping

This block sits on the outbound path of a PCIe host bridge. It takes a CPU-side MMIO address and returns three things: the address to place on the PCIe link, the number of the isolation partition that owns the target, and a flag that is set when no window claims the address. Each lookup takes one clock.

Two kinds of window are decoded. There is a single low window, limited to 32-bit-class sizes. It keeps the address bits below its size and replaces the bits above with a programmed translation value. Its span is cut into 256 equal segments, and a 256-entry remap table gives the partition of each segment. There are also sixteen high windows that forward the address untouched. Each high window is either whole or segmented:
- A whole window reports one programmed partition for its entire span.
- A segmented window splits its span into 256 segments and uses the segment index directly as the partition number.

Every window is a naturally aligned power-of-two region, programmed as a base and a log2 size. A configuration that is out of range or misaligned is refused, and that window reads as disabled. Windows may overlap; a fixed priority picks the winner.

Top module: `mmio_win_decode`

## Requirements
- R1: A lookup presented with `req_valid` high produces its result with `out_valid` high exactly one clock later; `out_valid` is low in every cycle that follows a clock without a request.
- R2: An address inside the enabled low window is translated so that bits below the window's log2 size are kept and every bit at or above it is taken from the programmed translation value.
- R3: For a low-window hit, the partition is the remap table entry indexed by address bits [lg-1:lg-8], where lg is the low window's log2 size; a table write changes the partition returned from the next lookup on.
- R4: A hit in a high window forwards the CPU address unchanged as the PCIe address.
- R5: A segmented high window reports address bits [lg-1:lg-8] as the partition, where lg is that window's log2 size.
- R6: A whole (unsegmented) high window reports its programmed partition for every address it covers.
- R7: On overlap, the lowest-numbered enabled high window wins, and any high window wins over the low window.
- R8: An address that no enabled window covers gives `out_miss`=1, `out_pe`=0 and `out_addr`=0.
- R9: A configuration write is refused, and leaves the window disabled, when the base has any bit set below the log2 size, or when the log2 size is outside 28..47 for a high window or outside 8..32 for the low window.
- R10: After reset all windows are disabled, every remap entry is 0 and `out_valid` is 0.
- R11: A configuration write with its enable bit at 0 disables the window, so that addresses it used to cover fall through to the next window in priority or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_we | input | 1 | Write strobe for the low window configuration |
| lo_on | input | 1 | Enable bit written to the low window |
| lo_base | input | AW (48) | Low window base address |
| lo_lg | input | LG_W (6) | Low window log2 size |
| lo_xlat | input | AW (48) | Replacement value for bits above the low window size |
| tbl_we | input | 1 | Remap table write strobe |
| tbl_idx | input | SEG_W (8) | Remap table entry index |
| tbl_pe | input | PE_W (8) | Partition written to the remap entry |
| hi_we | input | 1 | Write strobe for a high window |
| hi_idx | input | IDX_W (4) | Selected high window |
| hi_on | input | 1 | Enable bit written to the high window |
| hi_seg | input | 1 | 1 = segmented, 0 = whole window |
| hi_base | input | AW (48) | High window base address |
| hi_lg | input | LG_W (6) | High window log2 size |
| hi_pe | input | PE_W (8) | Partition for a whole high window |
| req_valid | input | 1 | Lookup request |
| req_addr | input | AW (48) | CPU-side address to decode |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_miss | output | 1 | No window covers the address |
| out_pe | output | PE_W (8) | Owning partition number |
| out_addr | output | AW (48) | PCIe-side address |

## Verification
A base or size register that holds a wrong value makes a lookup near a window edge land on the wrong side of that edge. The next result then shows it as a false miss, a false hit, or a partition taken from a neighbouring window. A wrong remap entry, or an off-by-one in the segment slice, shows up as a partition mismatch on the very next lookup that falls in that segment. An enable bit that survives a refused write turns an expected miss into a hit. The bench therefore probes the first and last bytes of windows and segments, plus the addresses just outside them. Every such fault appears one clock after the request.

// File: rtl/mwin_pkg.sv
package mwin_pkg;
  localparam int unsigned WIDE = 64;
  typedef logic [WIDE-1:0] wide_t;

  // ones in every bit position below lg
  function automatic wide_t low_mask(input int unsigned lg);
    if (lg >= WIDE) return '1;
    return (wide_t'(1) << lg) - wide_t'(1);
  endfunction

  // address lies in the aligned 2**lg region starting at base
  function automatic logic covers(input wide_t addr, input wide_t base,
                                  input int unsigned lg);
    return ((addr ^ base) & ~low_mask(lg)) == '0;
  endfunction

  // top segw bits of the in-window offset
  function automatic wide_t seg_of(input wide_t addr, input int unsigned lg,
                                   input int unsigned segw);
    if (lg < segw) return '0;
    return (addr & low_mask(lg)) >> (lg - segw);
  endfunction

  // size in range and base naturally aligned
  function automatic logic cfg_ok(input wide_t base, input int unsigned lg,
                                  input int unsigned lo, input int unsigned hi);
    return (lg >= lo) && (lg <= hi) && ((base & low_mask(lg)) == '0);
  endfunction

  // keep offset bits, take upper bits from repl
  function automatic wide_t splice(input wide_t addr, input wide_t repl,
                                   input int unsigned lg);
    return (addr & low_mask(lg)) | (repl & ~low_mask(lg));
  endfunction
endpackage

// File: rtl/mwin_slot64.sv
module mwin_slot64
  import mwin_pkg::*;
#(
  parameter int AW     = 48,
  parameter int PE_W   = 8,
  parameter int SEG_W  = 8,
  parameter int LG_W   = 6,
  parameter int IDX_W  = 4,
  parameter int SLOT   = 0,
  parameter int MIN_LG = 28,
  parameter int MAX_LG = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_on,
  input  logic             wr_seg,
  input  logic [AW-1:0]    wr_base,
  input  logic [LG_W-1:0]  wr_lg,
  input  logic [PE_W-1:0]  wr_pe,
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [PE_W-1:0]  pe
);
  logic             on_q, seg_q;
  logic [AW-1:0]    base_q;
  logic [LG_W-1:0]  lg_q;
  logic [PE_W-1:0]  pe_q;
  logic             wr_sel, wr_good;

  assign wr_sel  = wr_en && (wr_idx == IDX_W'(SLOT));
  assign wr_good = cfg_ok(WIDE'(wr_base), 32'(wr_lg), 32'(MIN_LG), 32'(MAX_LG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      seg_q  <= 1'b0;
      base_q <= '0;
      lg_q   <= '0;
      pe_q   <= '0;
    end else if (wr_sel) begin
      on_q   <= wr_on && wr_good;
      seg_q  <= wr_seg;
      base_q <= wr_base;
      lg_q   <= wr_lg;
      pe_q   <= wr_pe;
    end
  end

  assign hit = on_q && covers(WIDE'(addr), WIDE'(base_q), 32'(lg_q));
  assign pe  = seg_q ? PE_W'(seg_of(WIDE'(addr), 32'(lg_q), 32'(SEG_W))) : pe_q;

  // R9
  slot_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !wr_good) |=> !hit);

  // R11
  slot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !wr_on) |=> !hit);
endmodule

// File: rtl/mwin_low32.sv
module mwin_low32
  import mwin_pkg::*;
#(
  parameter int AW     = 48,
  parameter int PE_W   = 8,
  parameter int SEG_W  = 8,
  parameter int LG_W   = 6,
  parameter int MAX_LG = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_on,
  input  logic [AW-1:0]    wr_base,
  input  logic [LG_W-1:0]  wr_lg,
  input  logic [AW-1:0]    wr_xlat,
  input  logic             t_we,
  input  logic [SEG_W-1:0] t_idx,
  input  logic [PE_W-1:0]  t_pe,
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [PE_W-1:0]  pe,
  output logic [AW-1:0]    pci
);
  localparam int NSEG = 1 << SEG_W;

  logic             on_q;
  logic [AW-1:0]    base_q, xlat_q;
  logic [LG_W-1:0]  lg_q;
  logic [PE_W-1:0]  remap [NSEG];
  logic             wr_good;
  logic [SEG_W-1:0] seg;

  assign wr_good = cfg_ok(WIDE'(wr_base), 32'(wr_lg), 32'(SEG_W), 32'(MAX_LG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      base_q <= '0;
      xlat_q <= '0;
      lg_q   <= '0;
    end else if (wr_en) begin
      on_q   <= wr_on && wr_good;
      base_q <= wr_base;
      xlat_q <= wr_xlat;
      lg_q   <= wr_lg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) remap[i] <= '0;
    end else if (t_we) begin
      remap[t_idx] <= t_pe;
    end
  end

  assign hit = on_q && covers(WIDE'(addr), WIDE'(base_q), 32'(lg_q));
  assign seg = SEG_W'(seg_of(WIDE'(addr), 32'(lg_q), 32'(SEG_W)));
  assign pe  = remap[seg];
  assign pci = AW'(splice(WIDE'(addr), WIDE'(xlat_q), 32'(lg_q)));

  // R9
  low_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_good) |=> !hit);

  // R3
  low_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_we && !wr_en && hit && seg == t_idx && $stable(addr)) |=> (pe == $past(t_pe)));
endmodule

// File: rtl/mwin_pick.sv
module mwin_pick #(
  parameter int AW   = 48,
  parameter int PE_W = 8,
  parameter int N64  = 16
) (
  input  logic [N64-1:0]  hit64,
  input  logic [PE_W-1:0] pe64 [N64],
  input  logic            hit32,
  input  logic [PE_W-1:0] pe32,
  input  logic [AW-1:0]   pci32,
  input  logic [AW-1:0]   addr,
  output logic [N64:0]    grant,
  output logic            miss,
  output logic [PE_W-1:0] pe,
  output logic [AW-1:0]   pci
);
  always_comb begin
    grant = '0;
    pe    = '0;
    pci   = '0;
    miss  = 1'b1;
    // walk downward so the lowest index is the last writer
    for (int i = N64 - 1; i >= 0; i--) begin
      if (hit64[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        pe       = pe64[i];
      end
    end
    if (|hit64) begin
      pci  = addr;
      miss = 1'b0;
    end else if (hit32) begin
      grant[N64] = 1'b1;
      pe   = pe32;
      pci  = pci32;
      miss = 1'b0;
    end
  end
endmodule

// File: rtl/mmio_win_decode.sv
module mmio_win_decode #(
  parameter int AW         = 48,
  parameter int N64        = 16,
  parameter int SEG_W      = 8,
  parameter int PE_W       = 8,
  parameter int HI_MIN_LG  = 28,
  parameter int LO_MAX_LG  = 32,
  localparam int LG_W      = $clog2(AW + 1),
  localparam int IDX_W     = $clog2(N64)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic             lo_on,
  input  logic [AW-1:0]    lo_base,
  input  logic [LG_W-1:0]  lo_lg,
  input  logic [AW-1:0]    lo_xlat,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_idx,
  input  logic [PE_W-1:0]  tbl_pe,
  input  logic             hi_we,
  input  logic [IDX_W-1:0] hi_idx,
  input  logic             hi_on,
  input  logic             hi_seg,
  input  logic [AW-1:0]    hi_base,
  input  logic [LG_W-1:0]  hi_lg,
  input  logic [PE_W-1:0]  hi_pe,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic             out_valid,
  output logic             out_miss,
  output logic [PE_W-1:0]  out_pe,
  output logic [AW-1:0]    out_addr
);
  localparam int HI_MAX_LG = AW - 1;

  logic [N64-1:0]  hit64;
  logic [PE_W-1:0] pe64 [N64];
  logic            hit32;
  logic [PE_W-1:0] pe32;
  logic [AW-1:0]   pci32;
  logic [N64:0]    grant;
  logic            sel_miss;
  logic [PE_W-1:0] sel_pe;
  logic [AW-1:0]   sel_pci;

  for (genvar g = 0; g < N64; g++) begin : g_hi
    mwin_slot64 #(
      .AW(AW), .PE_W(PE_W), .SEG_W(SEG_W), .LG_W(LG_W), .IDX_W(IDX_W),
      .SLOT(g), .MIN_LG(HI_MIN_LG), .MAX_LG(HI_MAX_LG)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(hi_we), .wr_idx(hi_idx), .wr_on(hi_on), .wr_seg(hi_seg),
      .wr_base(hi_base), .wr_lg(hi_lg), .wr_pe(hi_pe),
      .addr(req_addr), .hit(hit64[g]), .pe(pe64[g])
    );
  end

  mwin_low32 #(
    .AW(AW), .PE_W(PE_W), .SEG_W(SEG_W), .LG_W(LG_W), .MAX_LG(LO_MAX_LG)
  ) u_low (
    .clk(clk), .rst_n(rst_n),
    .wr_en(lo_we), .wr_on(lo_on), .wr_base(lo_base), .wr_lg(lo_lg), .wr_xlat(lo_xlat),
    .t_we(tbl_we), .t_idx(tbl_idx), .t_pe(tbl_pe),
    .addr(req_addr), .hit(hit32), .pe(pe32), .pci(pci32)
  );

  mwin_pick #(.AW(AW), .PE_W(PE_W), .N64(N64)) u_pick (
    .hit64(hit64), .pe64(pe64), .hit32(hit32), .pe32(pe32), .pci32(pci32),
    .addr(req_addr), .grant(grant), .miss(sel_miss), .pe(sel_pe), .pci(sel_pci)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_pe    <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_miss <= sel_miss;
        out_pe   <= sel_pe;
        out_addr <= sel_pci;
      end
    end
  end

  // R1
  lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R1
  lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_pe == '0 && out_addr == '0));

  // R4
  hi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && |hit64) |=> (!out_miss && out_addr == $past(req_addr)));

  // R7
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(grant));

  // R7
  hi_over_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && |hit64 && hit32) |-> !grant[N64]);
endmodule

// File: tb/sim_mmio_win_decode.sv
module sim_mmio_win_decode;
  localparam int AW = 48;

  typedef struct {
    bit          miss;
    logic [7:0]  pe;
    logic [47:0] pci;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        lo_we = 0, lo_on = 0;
  logic [47:0] lo_base = '0, lo_xlat = '0;
  logic [5:0]  lo_lg = '0;
  logic        tbl_we = 0;
  logic [7:0]  tbl_idx = '0, tbl_pe = '0;
  logic        hi_we = 0, hi_on = 0, hi_seg = 0;
  logic [3:0]  hi_idx = '0;
  logic [47:0] hi_base = '0;
  logic [5:0]  hi_lg = '0;
  logic [7:0]  hi_pe = '0;
  logic        req_valid = 0;
  logic [47:0] req_addr = '0;
  logic        out_valid, out_miss;
  logic [7:0]  out_pe;
  logic [47:0] out_addr;

  int checks = 0;
  int errors = 0;
  exp_t sb_q[$];

  // bench-side configuration model
  bit          m_on [16];
  bit          m_seg [16];
  logic [47:0] m_base [16];
  int          m_lg [16];
  logic [7:0]  m_pe [16];
  bit          s_on = 0;
  logic [47:0] s_base = '0, s_xl = '0;
  int          s_lg = 0;
  logic [7:0]  s_tbl [256];

  always #5 clk = ~clk;

  mmio_win_decode u0 (
    .clk(clk), .rst_n(rst_n),
    .lo_we(lo_we), .lo_on(lo_on), .lo_base(lo_base), .lo_lg(lo_lg), .lo_xlat(lo_xlat),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_pe(tbl_pe),
    .hi_we(hi_we), .hi_idx(hi_idx), .hi_on(hi_on), .hi_seg(hi_seg),
    .hi_base(hi_base), .hi_lg(hi_lg), .hi_pe(hi_pe),
    .req_valid(req_valid), .req_addr(req_addr),
    .out_valid(out_valid), .out_miss(out_miss), .out_pe(out_pe), .out_addr(out_addr)
  );

  function automatic bit aligned_ok(logic [47:0] b, int lg, int lo, int hi);
    logic [63:0] span;
    if (lg < lo || lg > hi) return 0;
    span = 64'd1 << lg;
    return ({16'd0, b} % span) == 0;
  endfunction

  function automatic exp_t predict(logic [47:0] a, string tag);
    exp_t e;
    bit found = 0;
    e.miss = 1; e.pe = '0; e.pci = '0; e.tag = tag;
    for (int w = 0; w < 16; w++) begin
      if (!found && m_on[w] && ((a >> m_lg[w]) == (m_base[w] >> m_lg[w]))) begin
        found = 1;
        e.miss = 0;
        e.pci = a;
        e.pe = m_seg[w] ? 8'(a >> (m_lg[w] - 8)) : m_pe[w];
      end
    end
    if (!found && s_on && ((a >> s_lg) == (s_base >> s_lg))) begin
      e.miss = 0;
      e.pe = s_tbl[8'(a >> (s_lg - 8))];
      e.pci = ((s_xl >> s_lg) << s_lg) | (a - s_base);
    end
    return e;
  endfunction

  task automatic set_low(bit on, logic [47:0] b, int lg, logic [47:0] xl);
    lo_we = 1; lo_on = on; lo_base = b; lo_lg = 6'(lg); lo_xlat = xl;
    @(posedge clk); #1;
    lo_we = 0;
    s_on = on && aligned_ok(b, lg, 8, 32);
    s_base = b; s_lg = lg; s_xl = xl;
  endtask

  task automatic set_tbl(int idx, logic [7:0] p);
    tbl_we = 1; tbl_idx = 8'(idx); tbl_pe = p;
    @(posedge clk); #1;
    tbl_we = 0;
    s_tbl[idx] = p;
  endtask

  task automatic set_hi(int w, bit on, bit seg, logic [47:0] b, int lg, logic [7:0] p);
    hi_we = 1; hi_idx = 4'(w); hi_on = on; hi_seg = seg; hi_base = b; hi_lg = 6'(lg); hi_pe = p;
    @(posedge clk); #1;
    hi_we = 0;
    m_on[w] = on && aligned_ok(b, lg, 28, 47);
    m_seg[w] = seg; m_base[w] = b; m_lg[w] = lg; m_pe[w] = p;
  endtask

  task automatic look(logic [47:0] a, string tag);
    sb_q.push_back(predict(a, tag));
    req_valid = 1; req_addr = a;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // monitor: pops one expected item per valid result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result: actual valid=1 expected valid=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (out_miss !== e.miss || out_pe !== e.pe || out_addr !== e.pci) begin
          errors++;
          $display("FAIL %s: actual miss=%0b pe=%h addr=%h expected miss=%0b pe=%h addr=%h",
                   e.tag, out_miss, out_pe, out_addr, e.miss, e.pe, e.pci);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 16; w++) begin
      m_on[w] = 0; m_seg[w] = 0; m_base[w] = '0; m_lg[w] = 0; m_pe[w] = '0;
    end
    for (int i = 0; i < 256; i++) s_tbl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset valid: actual %0b expected 0", out_valid);
    end
    @(posedge clk); #1;

    // R10: nothing enabled after reset
    look(48'h10_0000_0000, "R10 reset miss");
    look(48'h40_0000_0000, "R8 miss empty map");

    // R2 / R3: low window, 2 GB, 8 MB segments
    set_low(1, 48'h10_0000_0000, 31, 48'h0000_8000_0000);
    for (int i = 0; i < 256; i++) set_tbl(i, 8'(i * 3 + 1));
    look(48'h10_0000_0012, "R2 R3 low first segment");
    look(48'h10_7FFF_FFFF, "R2 R3 low last byte segment 255");
    look(48'h10_3200_0ABC, "R3 low segment 100");
    look(48'h10_8000_0000, "R8 just above low window");
    set_tbl(100, 8'hEE);
    look(48'h10_3200_0ABC, "R3 remap rewrite");

    // R6 whole high window, R4 passthrough
    set_hi(3, 1, 0, 48'h20_0000_0000, 30, 8'h33);
    look(48'h20_0000_0000, "R6 R4 whole window first byte");
    look(48'h20_3FFF_FFFF, "R6 R4 whole window last byte");
    look(48'h20_4000_0000, "R8 just above whole window");

    // R5 segmented high window, 64 GB, 256 MB segments
    set_hi(5, 1, 1, 48'h40_0000_0000, 36, 8'h00);
    look(48'h40_7000_0055, "R5 segment 7");
    look(48'h4F_FFFF_FFFF, "R5 segment 255");
    look(48'h40_1000_0000, "R5 segment 1 first byte");

    // R7 lower high window wins over segmented window 5
    set_hi(2, 1, 0, 48'h40_0000_0000, 28, 8'h77);
    look(48'h40_0000_0100, "R7 window 2 over window 5");
    look(48'h40_1000_0000, "R7 outside window 2 falls to 5");

    // R9 refused configurations
    set_hi(0, 1, 0, 48'h60_0800_0000, 28, 8'h11);
    look(48'h60_0800_0000, "R9 misaligned high base");
    set_hi(4, 1, 0, 48'h70_0000_0000, 20, 8'h44);
    look(48'h70_0000_0000, "R9 high size too small");
    set_hi(6, 1, 0, 48'h00_0000_0000, 48, 8'h66);
    look(48'h00_0000_0000, "R9 high size too large");

    // R7 high window over low window
    set_hi(9, 1, 0, 48'h10_0000_0000, 32, 8'h99);
    look(48'h10_0000_0040, "R7 high over low");
    look(48'h10_8000_0000, "R7 high beyond low");

    // R11 disable via enable bit
    set_hi(9, 0, 0, 48'h10_0000_0000, 32, 8'h99);
    look(48'h10_0000_0040, "R11 disabled high falls to low");
    look(48'h10_8000_0000, "R11 disabled high now miss");

    // R9 low window refused
    set_low(1, 48'h10_4000_0000, 31, 48'h0000_8000_0000);
    look(48'h10_0000_0040, "R9 misaligned low base");
    look(48'h10_4000_0000, "R9 misaligned low base region");
    set_low(1, 48'h00_0000_0000, 33, 48'h0);
    look(48'h00_0000_0000, "R9 low size too large");

    // R1 back-to-back, mixed hits and misses
    set_low(1, 48'h10_0000_0000, 31, 48'h0000_8000_0000);
    look(48'h10_0080_0001, "R1 burst low");
    look(48'h20_0000_0008, "R1 burst high");
    look(48'h50_0000_0000, "R1 burst miss");
    look(48'h40_2000_0000, "R1 burst segmented");

    repeat (4) @(posedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R1 results outstanding: actual %0d expected 0", sb_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule